// File: doc/BRIEF.md
# Burst-Capable Control Write Decoder

This block sits behind a serial slave front end (I2C or SPI) that has already turned the wire traffic into whole bytes. Each transaction begins with a device byte that holds a 7-bit device address and a direction bit. Two subaddress bytes follow, high byte first. Every later byte is data. In a write, the decoder collects the data bytes into words and sends one write strobe to the register/memory map for each complete word. In a read, it fetches words and hands their bytes back to the front end, most significant byte first.

The word width depends on the subaddress. Locations at or above a register base (0xF000 by default) are 2-byte registers. Lower locations are 4-byte memory words. After every complete word the subaddress goes up by one, so a burst can run on without resending the address. A burst can cross from memory into register space, and the width changes at that point. A transaction ends when the front end pulses the end-of-frame input, which stands for an I2C stop or a rise of SPI slave select. Until the PLL-lock input is high, only a small window of PLL configuration subaddresses (0xF000 to 0xF004) can be reached. Accesses to any other subaddress produce no strobe.

Top module: `ctrl_write_decoder`

## Requirements
- R1: In the first byte after `frame_start`, bits [7:1] are compared with `dev_addr`, and bit 0 selects a read when it is 1 and a write when it is 0. On a mismatch, every later byte of the transaction is ignored and no strobe occurs.
- R2: The second and third bytes form the 16-bit subaddress, high byte first.
- R3: Subaddresses at or above 0xF000 take 2-byte words and lower ones take 4-byte words. Write data is assembled with the first byte as the most significant byte and is right-aligned in `wr_data`; the upper half is zero for 2-byte words. `mem_wide` reports the width of `mem_addr`.
- R4: After each complete word, the subaddress increases by exactly one. A burst continues across words, and across the width boundary, with no new address bytes.
- R5: `frame_end` returns the decoder to idle. A partly collected word is discarded and produces no write strobe.
- R6: While `pll_locked` is low, only subaddresses 0xF000 to 0xF004 produce `wr_stb` or `rd_stb`. Other accesses produce no strobe, and their read bytes are 0x00. The address still increments.
- R7: A read raises `rd_stb` for one cycle, two cycles after the last subaddress byte is accepted. It assumes `rd_data` is valid in that same cycle. The first byte appears on `tx_byte` one cycle later. Each `tx_req` shifts out one byte. The fetch of the next word begins in the cycle after the last byte of a word is shifted out.
- R8: When a byte and `frame_end` arrive in the same cycle, the byte is processed first. If it completes a word, the write strobe still follows in the next cycle.
- R9: `wr_stb` and `rd_stb` are one-cycle pulses, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Device address this decoder answers to |
| pll_locked | input | 1 | PLL lock indication; lifts the address gate |
| frame_start | input | 1 | Start of transaction (I2C start or slave-select fall) |
| frame_end | input | 1 | End of transaction (I2C stop or slave-select rise) |
| byte_valid | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| tx_req | input | 1 | Front end has shifted out the current read byte |
| rd_data | input | 32 | Read word from the map, valid while `rd_stb` is high |
| tx_byte | output | 8 | Read byte to be shifted out |
| wr_stb | output | 1 | Write strobe to the map |
| rd_stb | output | 1 | Read strobe to the map |
| mem_addr | output | 16 | Subaddress for the current strobe |
| mem_wide | output | 1 | High when `mem_addr` names a 4-byte location |
| wr_data | output | 32 | Right-aligned write word |

## Verification
The sharpest same-cycle case is a data byte that completes a word arriving in the same cycle as the end of the frame. The bench drives the final byte of a 2-byte word together with `frame_end`. The reference model then expects exactly one write strobe in the next cycle, and it expects a following partial word to produce nothing. A second overlap occurs during reads: the last `tx_req` of a word and the frame end fall close together, and the prefetch of the next word must still come out as a single `rd_stb` at the incremented address. This is judged against a queue of expected strobes that is compared on every clock.

// File: rtl/ctrl_write_decoder.sv
module ctrl_write_decoder #(
  parameter int          AW       = 16,
  parameter int          DW       = 32,
  parameter logic [15:0] REG_BASE = 16'hF000,
  parameter logic [15:0] GATE_LO  = 16'hF000,
  parameter logic [15:0] GATE_HI  = 16'hF004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    dev_addr,
  input  logic          pll_locked,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          tx_req,
  input  logic [DW-1:0] rd_data,
  output logic [7:0]    tx_byte,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wide,
  output logic [DW-1:0] wr_data
);
  localparam int HALF = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_SUBH, S_SUBL, S_DATA, S_SKIP} phase_t;

  phase_t        phase;
  logic          rw;
  logic [AW-1:0] addr;
  logic [DW-1:0] acc, shreg;
  logic [1:0]    bcnt;
  logic          fetch, load, rd_ok;

  function automatic logic allow(input logic [AW-1:0] a, input logic lk);
    return lk || (a >= GATE_LO && a <= GATE_HI);
  endfunction

  wire          cur_wide = addr < REG_BASE;
  wire [1:0]    last_idx = cur_wide ? 2'd3 : 2'd1;
  wire [DW-1:0] nacc     = {acc[DW-9:0], byte_data};

  assign mem_wide = mem_addr < REG_BASE;
  assign tx_byte  = shreg[DW-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      rw       <= 1'b0;
      addr     <= '0;
      acc      <= '0;
      shreg    <= '0;
      bcnt     <= '0;
      fetch    <= 1'b0;
      load     <= 1'b0;
      rd_ok    <= 1'b0;
      wr_stb   <= 1'b0;
      rd_stb   <= 1'b0;
      mem_addr <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;

      if (fetch) begin
        rd_stb   <= allow(addr, pll_locked);
        rd_ok    <= allow(addr, pll_locked);
        mem_addr <= addr;
        fetch    <= 1'b0;
        load     <= 1'b1;
      end

      if (load) begin
        load <= 1'b0;
        bcnt <= '0;
        if (!rd_ok)        shreg <= '0;
        else if (mem_wide) shreg <= rd_data;
        else               shreg <= {rd_data[HALF-1:0], {HALF{1'b0}}};
      end

      if (byte_valid) begin
        case (phase)
          S_DEV: begin
            if (byte_data[7:1] == dev_addr) begin
              rw    <= byte_data[0];
              phase <= S_SUBH;
            end else begin
              phase <= S_SKIP;
            end
          end
          S_SUBH: begin
            addr[AW-1:8] <= byte_data;
            phase        <= S_SUBL;
          end
          S_SUBL: begin
            addr[7:0] <= byte_data;
            phase     <= S_DATA;
            bcnt      <= '0;
            acc       <= '0;
            if (rw) fetch <= 1'b1;
          end
          S_DATA: begin
            if (!rw) begin
              if (bcnt == last_idx) begin
                wr_stb   <= allow(addr, pll_locked);
                wr_data  <= cur_wide ? nacc : {{HALF{1'b0}}, nacc[HALF-1:0]};
                mem_addr <= addr;
                addr     <= addr + 1'b1;
                bcnt     <= '0;
                acc      <= '0;
              end else begin
                acc  <= nacc;
                bcnt <= bcnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end

      if (tx_req && phase == S_DATA && rw && !fetch && !load) begin
        shreg <= {shreg[DW-9:0], 8'h00};
        if (bcnt == last_idx) begin
          bcnt  <= '0;
          addr  <= addr + 1'b1;
          fetch <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end

      if (frame_end) begin
        phase <= S_IDLE;
        bcnt  <= '0;
        acc   <= '0;
        load  <= 1'b0;
        shreg <= '0;
      end

      if (frame_start) begin
        phase <= S_DEV;
        bcnt  <= '0;
        acc   <= '0;
        fetch <= 1'b0;
        load  <= 1'b0;
        shreg <= '0;
      end
    end
  end

  p_excl_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));

  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  p_gate_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !$past(pll_locked)) |-> (mem_addr >= GATE_LO && mem_addr <= GATE_HI));

  p_gate_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !$past(pll_locked)) |-> (mem_addr >= GATE_LO && mem_addr <= GATE_HI));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (addr == mem_addr + 1'b1));

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !mem_wide) |-> (wr_data[DW-1:HALF] == '0));
endmodule

// File: tb/tb_ctrl_write_decoder.sv
`timescale 1ns/1ps
module tb_ctrl_write_decoder;
  localparam logic [6:0] DEV = 7'h3B;

  logic clk = 0, rst_n = 0;
  logic pll_locked = 0, frame_start = 0, frame_end = 0, byte_valid = 0, tx_req = 0;
  logic [7:0] byte_data = 0;
  logic [31:0] rd_data;
  logic [7:0] tx_byte;
  logic wr_stb, rd_stb, mem_wide;
  logic [15:0] mem_addr;
  logic [31:0] wr_data;

  int checks = 0, fails = 0;
  logic [15:0] wq_a[$], rq_a[$];
  logic [31:0] wq_d[$];

  always #2.5 clk = ~clk;
  assign rd_data = {mem_addr, ~mem_addr};

  ctrl_write_decoder dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(DEV), .pll_locked(pll_locked),
    .frame_start(frame_start), .frame_end(frame_end), .byte_valid(byte_valid),
    .byte_data(byte_data), .tx_req(tx_req), .rd_data(rd_data), .tx_byte(tx_byte),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .mem_addr(mem_addr), .mem_wide(mem_wide),
    .wr_data(wr_data));

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit gate_ok(logic [15:0] a);
    return pll_locked || (a >= 16'hF000 && a <= 16'hF004);
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin
      if (wq_a.size() == 0) chk(0, "R6", "unexpected wr_stb addr", mem_addr, 0);
      else begin
        automatic logic [15:0] a = wq_a.pop_front();
        automatic logic [31:0] d = wq_d.pop_front();
        chk(mem_addr == a, "R4", "write address", mem_addr, a);
        chk(wr_data == d, "R3", "write data", wr_data, d);
        chk(mem_wide == (a < 16'hF000), "R3", "width flag", mem_wide, a < 16'hF000);
      end
    end
    if (rd_stb) begin
      if (rq_a.size() == 0) chk(0, "R6", "unexpected rd_stb addr", mem_addr, 0);
      else begin
        automatic logic [15:0] a = rq_a.pop_front();
        chk(mem_addr == a, "R7", "read address", mem_addr, a);
      end
    end
    chk(!(wr_stb && rd_stb), "R9", "both strobes", {wr_stb, rd_stb}, 0);
  end

  task automatic put(logic [7:0] b, bit endnow = 0);
    @(negedge clk); byte_valid = 1; byte_data = b; frame_end = endnow;
    @(negedge clk); byte_valid = 0; frame_end = 0;
  endtask
  task automatic fstart();
    @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
  endtask
  task automatic fend();
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    repeat (2) @(negedge clk);
  endtask
  task automatic header(bit rw, logic [15:0] a, logic [6:0] dv = DEV);
    fstart(); put({dv, rw}); put(a[15:8]); put(a[7:0]);
  endtask
  task automatic wword(logic [15:0] a, logic [31:0] d, bit expect_it);
    if (a >= 16'hF000) begin
      put(d[15:8]); put(d[7:0]);
      if (expect_it) begin wq_a.push_back(a); wq_d.push_back({16'h0, d[15:0]}); end
    end else begin
      put(d[31:24]); put(d[23:16]); put(d[15:8]); put(d[7:0]);
      if (expect_it) begin wq_a.push_back(a); wq_d.push_back(d); end
    end
  endtask
  task automatic rword(logic [15:0] a);
    automatic int n = (a >= 16'hF000) ? 2 : 4;
    automatic logic [31:0] w = gate_ok(a) ? {a, ~a} : 32'h0;
    automatic logic [31:0] al = (n == 4) ? w : {w[15:0], 16'h0};
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      chk(tx_byte == al[31-8*i -: 8], "R7", "read byte", tx_byte, al[31-8*i -: 8]);
      if (i == n - 1 && gate_ok(a + 16'd1)) rq_a.push_back(a + 16'd1);
      tx_req = 1; @(negedge clk); tx_req = 0;
    end
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_stb == 0 && rd_stb == 0 && tx_byte == 0, "R9", "reset state",
        {wr_stb, rd_stb, tx_byte}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R6 R4 R2: unlocked, PLL window burst then leaving the window
    header(0, 16'hF000);
    wword(16'hF000, 32'h1111, 1); wword(16'hF001, 32'h2222, 1); wword(16'hF002, 32'h3333, 1);
    fend();
    header(0, 16'hF003);
    wword(16'hF003, 32'hA1A2, 1); wword(16'hF004, 32'hB1B2, 1);
    wword(16'hF005, 32'hC1C2, 0); wword(16'hF006, 32'hD1D2, 0);
    fend();
    // R6: memory write before lock ignored
    header(0, 16'h0010); wword(16'h0010, 32'hDEADBEEF, 0); fend();
    chk(wq_a.size() == 0, "R6", "pending writes after gated burst", wq_a.size(), 0);

    pll_locked = 1;
    // R3 R4: burst across width boundary
    header(0, 16'hEFFE);
    wword(16'hEFFE, 32'h01020304, 1); wword(16'hEFFF, 32'h05060708, 1);
    wword(16'hF000, 32'h090A, 1); wword(16'hF001, 32'h0B0C, 1);
    fend();
    // R1: device mismatch
    header(0, 16'h0040, 7'h3A); wword(16'h0040, 32'h55667788, 0); fend();
    // R5: partial word discarded
    header(0, 16'h0100); wword(16'h0100, 32'hCAFEF00D, 1);
    put(8'h11); put(8'h22); put(8'h33); fend();
    // R8: final byte together with frame end
    header(0, 16'hF010); put(8'h9A); put(8'hBC, 1);
    wq_a.push_back(16'hF010); wq_d.push_back(32'h9ABC);
    repeat (3) @(negedge clk);
    chk(wq_a.size() == 0, "R8", "write on same-cycle end", wq_a.size(), 0);
    put(8'h77); repeat (2) @(negedge clk);

    // R7 R1: reads, memory and register words
    rq_a.push_back(16'h0020);
    header(1, 16'h0020); rword(16'h0020); rword(16'h0021); fend();
    rq_a.push_back(16'hF001);
    header(1, 16'hF001); rword(16'hF001); rword(16'hF002); fend();

    // R6: gated read returns zeros, no strobe; window read still works
    pll_locked = 0;
    header(1, 16'h0030); rword(16'h0030); fend();
    rq_a.push_back(16'hF003);
    header(1, 16'hF003); rword(16'hF003); rword(16'hF004); fend();

    repeat (5) @(negedge clk);
    chk(wq_a.size() == 0, "R5", "write queue drained", wq_a.size(), 0);
    chk(rq_a.size() == 0, "R7", "read queue drained", rq_a.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule